// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Thresholds

This block buffers words between two clock domains whose clocks share no frequency or phase relation. A producer pushes words on the write clock and sees a full flag and a near-full flag in that domain. A consumer pops words on the read clock and sees an empty flag and a near-empty flag in its own domain. Each side keeps an extended binary position counter. The counter crosses to the other domain in Gray code through a two-stage synchronizer, and each side compares its own next position with the synchronized position of the other side.

The near thresholds are live inputs, so the consumer or producer can move them at any time. Each threshold is an exact entry count with a step of one entry. Storage holds `2**ADDR_W` words and the usable capacity is `2**ADDR_W - 1`. EMPTY rises on the same read edge that returns the last stored word. Both domains have their own active-high synchronous reset, which is stretched internally by two clocks of its domain.

Top module: `xclk_fifo`

## Requirements
- R1: Every accepted word comes out of `rdata_o` unchanged and in write order, one read clock edge after the read that takes it.
- R2: The FIFO holds at most `2**ADDR_W - 1` words. A write presented while `full_o` is high is dropped and never reaches the read side.
- R3: With the read side idle and synchronized, `full_o` rises on the write edge that stores word number `2**ADDR_W - 1`, and stays low before that.
- R4: `empty_o` rises on the read edge that takes the last stored word, with no extra cycle.
- R5: A read presented while `empty_o` is high is dropped: `rdata_o` keeps its value, and the next word written is the next word read.
- R6: `afull_o` is high when the write-side fill count, measured against the synchronized read position, is greater than or equal to `af_thr_i`, a plain unsigned entry count.
- R7: `aempty_o` is high when the read-side fill count, measured against the synchronized write position, is less than or equal to `ae_thr_i`, a plain unsigned entry count.
- R8: A new threshold value takes effect at the next edge of its own domain's clock, with no other traffic.
- R9: While reset is held and right after it, `empty_o` and `aempty_o` are high and `full_o` and `afull_o` are low. The near-empty flag stays high only while the threshold is at least zero entries.
- R10: After a write into an empty, idle FIFO, `empty_o` falls no later than the fourth read clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write domain clock |
| wrst_i | input | 1 | Write domain reset, active high, synchronous |
| wen_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Word to store |
| af_thr_i | input | ADDR_W+1 | Near-full threshold in entries |
| full_o | output | 1 | No room for another word (write domain) |
| afull_o | output | 1 | Fill count at or above near-full threshold |
| rclk_i | input | 1 | Read domain clock |
| rrst_i | input | 1 | Read domain reset, active high, synchronous |
| ren_i | input | 1 | Read request |
| ae_thr_i | input | ADDR_W+1 | Near-empty threshold in entries |
| rdata_o | output | DATA_W | Word taken by the last accepted read |
| empty_o | output | 1 | No word available (read domain) |
| aempty_o | output | 1 | Fill count at or below near-empty threshold |

## Verification
A corrupted read position shows at `rdata_o` on the next accepted read, as a word out of order or a repeated word. A corrupted write position shows as a lost or stale word once that slot is read back. A wrong fill count shows as a flag that is off by one entry. This is seen on the very edge that crosses a threshold or the capacity, so the bench samples every flag right after each single-word step through those points. Crossing faults show as a late EMPTY release, or as the writer stalling while a Gray pointer jumps more than one bit per edge.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;

    // widest extended position a side may carry (ADDR_W + 1 <= PTR_MAX)
    localparam int PTR_MAX = 16;

    typedef logic [PTR_MAX-1:0] ptr_wide_t;

    // pair of level indications produced by one side
    typedef struct packed {
        logic edge_f;   // full on the write side, empty on the read side
        logic near_f;   // threshold comparison result
    } level_flags_t;

    function automatic ptr_wide_t to_gray(input ptr_wide_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_wide_t from_gray(input ptr_wide_t g);
        ptr_wide_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xclk_fifo_sync2.sv
`timescale 1ns/1ps
module xclk_fifo_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RST_VAL;
            q       <= RST_VAL;
        end else begin
            stage_q <= d;
            q       <= stage_q;
        end
    end

endmodule

// File: rtl/xclk_fifo_side.sv
`timescale 1ns/1ps
module xclk_fifo_side
    import xclk_fifo_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter bit IS_WRITE = 1'b1,
    localparam int PW      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [PW-1:0]     near_thr,
    input  logic [PW-1:0]     peer_gray,
    output logic [ADDR_W-1:0] addr,
    output logic              fire,
    output logic [PW-1:0]     own_gray,
    output level_flags_t      flags
);

    localparam logic [PW-1:0] CAP = PW'((1 << ADDR_W) - 1);
    localparam level_flags_t  FLAG_RST = IS_WRITE ? level_flags_t'(2'b00)
                                                  : level_flags_t'(2'b11);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos_n;
    logic [PW-1:0] peer_pos;
    logic [PW-1:0] fill_n;
    level_flags_t  flags_n;

    always_comb begin
        fire     = req & ~flags.edge_f;
        pos_n    = pos_q + {{ADDR_W{1'b0}}, fire};
        peer_pos = PW'(from_gray(ptr_wide_t'(peer_gray)));
    end

    generate
        if (IS_WRITE) begin : g_wr
            always_comb begin
                fill_n         = pos_n - peer_pos;
                flags_n.edge_f = (fill_n >= CAP);
                flags_n.near_f = (fill_n >= near_thr);
            end
        end else begin : g_rd
            always_comb begin
                fill_n         = peer_pos - pos_n;
                flags_n.edge_f = (fill_n == '0);
                flags_n.near_f = (fill_n <= near_thr);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            own_gray <= '0;
            flags    <= FLAG_RST;
        end else begin
            pos_q    <= pos_n;
            own_gray <= PW'(to_gray(ptr_wide_t'(pos_n)));
            flags    <= flags_n;
        end
    end

    assign addr = pos_q[ADDR_W-1:0];

endmodule

// File: rtl/xclk_fifo_store.sv
`timescale 1ns/1ps
module xclk_fifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              wclk_i,
    input  logic              wrst_i,
    input  logic              wen_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PW-1:0]     af_thr_i,
    output logic              full_o,
    output logic              afull_o,
    input  logic              rclk_i,
    input  logic              rrst_i,
    input  logic              ren_i,
    input  logic [PW-1:0]     ae_thr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              empty_o,
    output logic              aempty_o
);

    logic              w_hold, r_hold;
    logic              w_rst, r_rst;
    logic [PW-1:0]     w_gray, r_gray;
    logic [PW-1:0]     r_gray_in_w, w_gray_in_r;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic              w_fire, r_fire;
    level_flags_t      w_flags, r_flags;

    // reset stretchers, one per domain
    xclk_fifo_sync2 #(.W(1), .RST_VAL(1'b1)) u_wrst (
        .clk(wclk_i), .rst(wrst_i), .d(1'b0), .q(w_hold)
    );
    xclk_fifo_sync2 #(.W(1), .RST_VAL(1'b1)) u_rrst (
        .clk(rclk_i), .rst(rrst_i), .d(1'b0), .q(r_hold)
    );
    assign w_rst = wrst_i | w_hold;
    assign r_rst = rrst_i | r_hold;

    // Gray position crossings
    xclk_fifo_sync2 #(.W(PW), .RST_VAL('0)) u_r2w (
        .clk(wclk_i), .rst(w_rst), .d(r_gray), .q(r_gray_in_w)
    );
    xclk_fifo_sync2 #(.W(PW), .RST_VAL('0)) u_w2r (
        .clk(rclk_i), .rst(r_rst), .d(w_gray), .q(w_gray_in_r)
    );

    xclk_fifo_side #(.ADDR_W(ADDR_W), .IS_WRITE(1'b1)) u_wside (
        .clk      (wclk_i),
        .rst      (w_rst),
        .req      (wen_i),
        .near_thr (af_thr_i),
        .peer_gray(r_gray_in_w),
        .addr     (w_addr),
        .fire     (w_fire),
        .own_gray (w_gray),
        .flags    (w_flags)
    );

    xclk_fifo_side #(.ADDR_W(ADDR_W), .IS_WRITE(1'b0)) u_rside (
        .clk      (rclk_i),
        .rst      (r_rst),
        .req      (ren_i),
        .near_thr (ae_thr_i),
        .peer_gray(w_gray_in_r),
        .addr     (r_addr),
        .fire     (r_fire),
        .own_gray (r_gray),
        .flags    (r_flags)
    );

    xclk_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk (wclk_i),
        .we   (w_fire),
        .waddr(w_addr),
        .wdata(wdata_i),
        .rclk (rclk_i),
        .re   (r_fire),
        .raddr(r_addr),
        .rdata(rdata_o)
    );

    assign full_o   = w_flags.edge_f;
    assign afull_o  = w_flags.near_f;
    assign empty_o  = r_flags.edge_f;
    assign aempty_o = r_flags.near_f;

endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int PW    = ADDR_W + 1
) (
    input logic              wclk,
    input logic              rclk,
    input logic              w_rst,
    input logic              r_rst,
    input logic              wen,
    input logic              full,
    input logic              afull,
    input logic [PW-1:0]     af_thr,
    input logic              empty,
    input logic              aempty,
    input logic [DATA_W-1:0] rdata,
    input logic [PW-1:0]     w_gray,
    input logic [PW-1:0]     r_gray
);

    localparam logic [PW-1:0] CAP = PW'((1 << ADDR_W) - 1);

    // R1
    wgray_step_chk: assert property (@(posedge wclk) disable iff (w_rst)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    // R1
    rgray_step_chk: assert property (@(posedge rclk) disable iff (r_rst)
        $countones(r_gray ^ $past(r_gray)) <= 1);

    // R2
    no_overflow_chk: assert property (@(posedge wclk) disable iff (w_rst)
        full |=> $stable(w_gray));

    // R2
    accept_chk: assert property (@(posedge wclk) disable iff (w_rst)
        (wen && !full) |=> (w_gray != $past(w_gray)));

    // R5
    empty_hold_chk: assert property (@(posedge rclk) disable iff (r_rst)
        empty |=> ($stable(rdata) && $stable(r_gray)));

    // R7
    empty_near_chk: assert property (@(posedge rclk) disable iff (r_rst)
        empty |-> aempty);

    // R6
    full_near_chk: assert property (@(posedge wclk) disable iff (w_rst)
        (full && ($past(af_thr) <= CAP)) |-> afull);

endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .wclk  (wclk_i),
    .rclk  (rclk_i),
    .w_rst (w_rst),
    .r_rst (r_rst),
    .wen   (wen_i),
    .full  (full_o),
    .afull (afull_o),
    .af_thr(af_thr_i),
    .empty (empty_o),
    .aempty(aempty_o),
    .rdata (rdata_o),
    .w_gray(w_gray),
    .r_gray(r_gray)
);

// File: tb/xclk_fifo_tb_top.sv
`timescale 1ns/1ps
module xclk_fifo_tb_top;

    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int CAP = (1 << AW) - 1;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          wrst = 1'b1;
    logic          rrst = 1'b1;
    logic          wen  = 1'b0;
    logic          ren  = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [AW:0]   af_thr = 5'd12;
    logic [AW:0]   ae_thr = 5'd2;
    logic [DW-1:0] rdata;
    logic          full, afull, empty, aempty;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_q [$];

    always #2.0 wclk = ~wclk;   // 250 MHz write clock
    always #3.5 rclk = ~rclk;   // unrelated read clock

    xclk_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .wclk_i  (wclk),
        .wrst_i  (wrst),
        .wen_i   (wen),
        .wdata_i (wdata),
        .af_thr_i(af_thr),
        .full_o  (full),
        .afull_o (afull),
        .rclk_i  (rclk),
        .rrst_i  (rrst),
        .ren_i   (ren),
        .ae_thr_i(ae_thr),
        .rdata_o (rdata),
        .empty_o (empty),
        .aempty_o(aempty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // driver: presents one word, records it as expected if the FIFO had room
    task automatic push_word(input logic [DW-1:0] d, output bit acc);
        @(negedge wclk);
        acc   = !full;
        wen   = 1'b1;
        wdata = d;
        @(posedge wclk);
        #1;
        wen = 1'b0;
        if (acc) exp_q.push_back(d);
    endtask

    // monitor: takes one word when available and compares it with the queue head
    task automatic pull_word(output bit got);
        logic [DW-1:0] e;
        @(negedge rclk);
        got = !empty;
        ren = 1'b1;
        @(posedge rclk);
        #1;
        ren = 1'b0;
        if (got) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", int'(rdata), -1);
            end else begin
                e = exp_q.pop_front();
                check(rdata == e, "R1", int'(rdata), int'(e));
            end
        end
    endtask

    task automatic settle();
        repeat (10) @(posedge rclk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        bit acc, got;
        logic [DW-1:0] hold;
        int k;

        // reset state (R9)
        repeat (4) @(posedge rclk);
        #1;
        check(empty == 1'b1,  "R9", empty, 1);
        check(aempty == 1'b1, "R9", aempty, 1);
        check(full == 1'b0,   "R9", full, 0);
        check(afull == 1'b0,  "R9", afull, 0);
        @(negedge wclk) wrst = 1'b0;
        @(negedge rclk) rrst = 1'b0;
        settle();
        check(empty == 1'b1 && aempty == 1'b1, "R9", {empty, aempty}, 3);
        check(full == 1'b0 && afull == 1'b0,   "R9", {full, afull}, 0);

        // R10: empty release latency
        push_word(8'h33, acc);
        k = 0;
        for (int i = 1; i <= 8; i++) begin
            @(posedge rclk);
            #1;
            if (!empty) begin
                k = i;
                break;
            end
        end
        check(k >= 1 && k <= 4, "R10", k, 4);
        settle();
        // R4: last word leaves and empty rises on the same edge
        pull_word(got);
        check(got, "R4", got, 1);
        check(empty == 1'b1, "R4", empty, 1);

        // R5: read on empty is dropped
        hold = rdata;
        pull_word(got);
        check(!got, "R5", got, 0);
        check(rdata == hold, "R5", rdata, hold);
        check(empty == 1'b1, "R5", empty, 1);
        push_word(8'h5A, acc);
        settle();
        pull_word(got);   // must return 0x5A (R5, compared against queue)
        check(got, "R5", got, 1);
        settle();

        // fill step by step: R3 full edge, R6 near-full threshold 12
        for (int n = 1; n <= CAP; n++) begin
            push_word(8'h10 + 8'(n), acc);
            check(acc, "R2", acc, 1);
            check(full == (n == CAP), "R3", full, int'(n == CAP));
            check(afull == (n >= 12), "R6", afull, int'(n >= 12));
        end
        // R2: write beyond capacity is dropped
        push_word(8'hEE, acc);
        check(!acc, "R2", acc, 0);
        check(full == 1'b1, "R2", full, 1);
        settle();

        // drain: R4 empty edge, R7 near-empty threshold 2
        for (int n = 1; n <= CAP; n++) begin
            pull_word(got);
            check(got, "R2", got, 1);
            check(empty == (n == CAP), "R4", empty, int'(n == CAP));
            check(aempty == ((CAP - n) <= 2), "R7", aempty, int'((CAP - n) <= 2));
        end
        settle();
        check(empty == 1'b1, "R2", empty, 1);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);

        // R8: thresholds move at run time with 5 words stored
        for (int n = 0; n < 5; n++) push_word(8'h40 + 8'(n), acc);
        settle();
        @(negedge wclk) af_thr = 5'd5;
        @(posedge wclk);
        #1;
        check(afull == 1'b1, "R8", afull, 1);
        @(negedge wclk) af_thr = 5'd6;
        @(posedge wclk);
        #1;
        check(afull == 1'b0, "R8", afull, 0);
        @(negedge rclk) ae_thr = 5'd5;
        @(posedge rclk);
        #1;
        check(aempty == 1'b1, "R8", aempty, 1);
        @(negedge rclk) ae_thr = 5'd4;
        @(posedge rclk);
        #1;
        check(aempty == 1'b0, "R8", aempty, 0);
        af_thr = 5'd12;
        ae_thr = 5'd2;
        for (int n = 0; n < 5; n++) pull_word(got);
        check(empty == 1'b1, "R4", empty, 1);

        // R1: concurrent streaming with irregular gaps on both sides
        fork
            begin
                bit a;
                for (int i = 0; i < 150; i++) begin
                    a = 1'b0;
                    while (!a) push_word(8'(i * 7 + 3), a);
                    repeat ($urandom_range(0, 2)) @(posedge wclk);
                end
            end
            begin
                bit g;
                int taken = 0;
                while (taken < 150) begin
                    pull_word(g);
                    if (g) taken++;
                    repeat ($urandom_range(0, 3)) @(posedge rclk);
                end
            end
        join
        check(exp_q.size() == 0, "R1", exp_q.size(), 0);
        check(empty == 1'b1, "R4", empty, 1);

        finish_run();
    end

endmodule